// File: doc/BRIEF.md
# Slave Serial Audio Receiver

This block receives a two-channel serial audio stream as a slave. It does not generate any clocks. The bit clock, frame clock and data lines come from an external master. All three are sampled by a faster system clock, and the rising edges of the bit clock are detected in that domain. On each detected edge the block takes one frame-clock bit and one data bit. It rebuilds a left and a right two's-complement word, MSB first, at a parameterised output width.

The sender's word length may differ from the output width. Extra low-order bits are dropped, and missing low-order bits are filled with zero. Two framings are supported, chosen by a static select input:
- **Standard:** the MSB comes one bit clock after the frame-clock change.
- **Left-justified:** the MSB comes on the same bit clock as the frame-clock change.

Channel boundaries are taken only from frame-clock transitions, so slots of unequal length are accepted. When a right word completes after a left word, the pair is presented with a one-cycle valid strobe. The pair is then held until the next one.

Top module: `serial_audio_rx`

## Requirements
- R1: Frame-clock and data inputs are sampled once per rising edge of the bit clock. Each input passes through a two-stage synchronizer first. The system clock runs at least 4 times the bit-clock rate.
- R2: A sampled frame-clock value of 0 marks left-channel data, and a value of 1 marks right-channel data. Left words appear on `left_o` and right words on `right_o`.
- R3: With `fmt_sel` = 0 (standard framing), the data bit sampled on the edge where a frame-clock change is first seen is not part of the new word; it closes the previous word. The new word's MSB is sampled on the next rising edge.
- R4: With `fmt_sel` = 1 (left-justified framing), the new word's MSB is the data bit sampled on the same rising edge where the frame-clock change is first seen.
- R5: When the sender supplies more bits per word than OUT_W, only the first OUT_W bits (the MSB side) are kept, and the remaining low-order bits are discarded.
- R6: When the sender supplies fewer bits than OUT_W, the received bits occupy the MSB side, and the unfilled low-order bits read 0.
- R7: A word ends only at the next frame-clock transition. Left and right slots of different lengths are both decoded correctly.
- R8: `valid_o` pulses high for exactly one system clock cycle after a right word completes that follows a left word. `left_o` and `right_o` change only in that cycle and hold their values otherwise.
- R9: After reset, no pair is emitted until a left word and then a right word have each been started by an observed frame-clock transition. A right word with no preceding complete left word is dropped.
- R10: While reset is asserted, and after reset until the first pair, `valid_o` is 0 and `left_o` and `right_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the bit-clock rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fmt_sel | input | 1 | Framing select: 0 standard, 1 left-justified |
| bit_clk_i | input | 1 | Serial bit clock from the external master |
| frame_clk_i | input | 1 | Channel-select line from the master (0 left, 1 right) |
| ser_data_i | input | 1 | Serial audio data, MSB first |
| left_o | output | OUT_W | Last completed left-channel word |
| right_o | output | OUT_W | Last completed right-channel word |
| valid_o | output | 1 | One-cycle strobe marking a new left/right pair |

## Verification
The embedded assertions check the following properties on every cycle:
- Detected bit-clock edges are never back to back.
- The bit counter never passes the output width.
- The valid strobe never lasts two cycles.
- The output pair never moves outside a strobe.

The bench scenarios check the rest. These are the placement of the MSB under each framing, truncation and zero-fill of words, channel assignment, unequal slot lengths, and the discarding of a partial start after reset. For each of these it compares every emitted pair against words computed from the serial stream it drove.

// File: rtl/sarx_pkg.sv
package sarx_pkg;
  typedef enum logic {
    FMT_STD = 1'b0,
    FMT_LJ  = 1'b1
  } sarx_fmt_e;

  localparam int unsigned LINE_CNT = 3;
endpackage

// File: rtl/sarx_front.sv
module sarx_front
  import sarx_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic bit_clk_i,
  input  logic frame_clk_i,
  input  logic ser_data_i,
  output logic bit_stb_o,
  output logic ws_bit_o,
  output logic sd_bit_o
);
  localparam int unsigned TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0][LINE_CNT-1:0] chain_q;
  logic [LINE_CNT-1:0] raw;
  logic                sck_d_q;

  assign raw = {bit_clk_i, frame_clk_i, ser_data_i};

  // one synchronizer chain per input line
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
      sck_d_q <= 1'b0;
    end else begin
      chain_q[0] <= raw;
      for (int s = 1; s < SYNC_STAGES; s++) chain_q[s] <= chain_q[s-1];
      sck_d_q <= chain_q[TOP][2];
    end
  end

  assign bit_stb_o = chain_q[TOP][2] & ~sck_d_q;
  assign ws_bit_o  = chain_q[TOP][1];
  assign sd_bit_o  = chain_q[TOP][0];

  AST_EDGE_SPACING: assert property (@(posedge clk) disable iff (!rst_ni)
    bit_stb_o |=> !bit_stb_o); // R1
endmodule

// File: rtl/sarx_deser.sv
module sarx_deser
  import sarx_pkg::*;
#(
  parameter int unsigned OUT_W = 16
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  sarx_fmt_e        fmt_i,
  input  logic             bit_stb_i,
  input  logic             ws_bit_i,
  input  logic             sd_bit_i,
  output logic             word_stb_o,
  output logic             word_ch_o,
  output logic [OUT_W-1:0] word_data_o
);
  localparam int unsigned CW = $clog2(OUT_W + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(OUT_W);
  localparam logic [OUT_W-1:0] TOP_BIT = {1'b1, {(OUT_W-1){1'b0}}};

  logic             armed_q, armed_d;
  logic             locked_q, locked_d;
  logic             ws_prev_q, ws_prev_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [OUT_W-1:0] sh_q, sh_d;
  logic [OUT_W-1:0] ins;
  logic             chg;

  always_comb begin
    ins = sh_q;
    if ((cnt_q < CNT_MAX) && sd_bit_i) ins = sh_q | (TOP_BIT >> cnt_q);
    chg = bit_stb_i & armed_q & (ws_bit_i != ws_prev_q);

    armed_d   = armed_q | bit_stb_i;
    locked_d  = locked_q | chg;
    ws_prev_d = bit_stb_i ? ws_bit_i : ws_prev_q;
    cnt_d     = cnt_q;
    sh_d      = sh_q;
    if (bit_stb_i) begin
      if (chg) begin
        if (fmt_i == FMT_STD) begin
          sh_d  = '0;
          cnt_d = '0;
        end else begin
          sh_d  = sd_bit_i ? TOP_BIT : '0;
          cnt_d = CW'(1);
        end
      end else begin
        sh_d  = ins;
        cnt_d = (cnt_q < CNT_MAX) ? cnt_q + CW'(1) : cnt_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q   <= 1'b0;
      locked_q  <= 1'b0;
      ws_prev_q <= 1'b0;
      cnt_q     <= '0;
      sh_q      <= '0;
    end else begin
      armed_q   <= armed_d;
      locked_q  <= locked_d;
      ws_prev_q <= ws_prev_d;
      cnt_q     <= cnt_d;
      sh_q      <= sh_d;
    end
  end

  // standard framing: the bit seen at the change closes the old word
  assign word_stb_o  = chg & locked_q;
  assign word_ch_o   = ws_prev_q;
  assign word_data_o = (fmt_i == FMT_STD) ? ins : sh_q;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_ni)
    cnt_q <= CNT_MAX); // R5
endmodule

// File: rtl/sarx_pair.sv
module sarx_pair #(
  parameter int unsigned OUT_W = 16
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             word_stb_i,
  input  logic             word_ch_i,
  input  logic [OUT_W-1:0] word_data_i,
  output logic [OUT_W-1:0] left_o,
  output logic [OUT_W-1:0] right_o,
  output logic             valid_o
);
  logic [OUT_W-1:0] hold_q, hold_d;
  logic             have_q, have_d;
  logic [OUT_W-1:0] left_d, right_d;
  logic             valid_d;

  always_comb begin
    hold_d  = hold_q;
    have_d  = have_q;
    left_d  = left_o;
    right_d = right_o;
    valid_d = 1'b0;
    if (word_stb_i) begin
      if (!word_ch_i) begin
        hold_d = word_data_i;
        have_d = 1'b1;
      end else if (have_q) begin
        left_d  = hold_q;
        right_d = word_data_i;
        valid_d = 1'b1;
        have_d  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q  <= '0;
      have_q  <= 1'b0;
      left_o  <= '0;
      right_o <= '0;
      valid_o <= 1'b0;
    end else begin
      hold_q  <= hold_d;
      have_q  <= have_d;
      left_o  <= left_d;
      right_o <= right_d;
      valid_o <= valid_d;
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R8
  AST_PAIR_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    !valid_o |-> ($stable(left_o) && $stable(right_o))); // R8
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import sarx_pkg::*;
#(
  parameter int unsigned OUT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fmt_sel,
  input  logic             bit_clk_i,
  input  logic             frame_clk_i,
  input  logic             ser_data_i,
  output logic [OUT_W-1:0] left_o,
  output logic [OUT_W-1:0] right_o,
  output logic             valid_o
);
  logic [1:0]       rst_pipe_q;
  logic             rst_int_n;
  logic             bit_stb, ws_bit, sd_bit;
  logic             word_stb, word_ch;
  logic [OUT_W-1:0] word_data;
  sarx_fmt_e        fmt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];
  assign fmt       = sarx_fmt_e'(fmt_sel);

  sarx_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst_ni(rst_int_n),
    .bit_clk_i(bit_clk_i), .frame_clk_i(frame_clk_i), .ser_data_i(ser_data_i),
    .bit_stb_o(bit_stb), .ws_bit_o(ws_bit), .sd_bit_o(sd_bit)
  );

  sarx_deser #(.OUT_W(OUT_W)) u_deser (
    .clk(clk), .rst_ni(rst_int_n), .fmt_i(fmt),
    .bit_stb_i(bit_stb), .ws_bit_i(ws_bit), .sd_bit_i(sd_bit),
    .word_stb_o(word_stb), .word_ch_o(word_ch), .word_data_o(word_data)
  );

  sarx_pair #(.OUT_W(OUT_W)) u_pair (
    .clk(clk), .rst_ni(rst_int_n),
    .word_stb_i(word_stb), .word_ch_i(word_ch), .word_data_i(word_data),
    .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
  );
endmodule

// File: tb/sim_serial_audio_rx.sv
module sim_serial_audio_rx;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n, fmt_sel, sck, ws, sd;
  logic [W-1:0] left_o, right_o;
  logic valid_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [2*W-1:0] exp_q[$];
  string          tag_q[$];
  logic [2*W-1:0] last_pair = '0;

  always #10 clk = ~clk;

  serial_audio_rx #(.OUT_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel),
    .bit_clk_i(sck), .frame_clk_i(ws), .ser_data_i(sd),
    .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] expw(input logic [31:0] v, input int wl);
    logic [31:0] m;
    m = (wl >= 32) ? v : (v & ((32'd1 << wl) - 32'd1));
    if (wl >= W) return W'(m >> (wl - W));
    return W'(m << (W - wl));
  endfunction

  // monitor: compare every emitted pair with the scoreboard head
  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      if (exp_q.size() == 0) begin
        check("R9 spurious pair", {left_o, right_o}, 64'hDEAD);
      end else begin
        logic [2*W-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({t, " left"}, left_o, e[2*W-1:W]);
        check({t, " right R2"}, right_o, e[W-1:0]);
        last_pair = e;
      end
    end
  end

  task automatic send_bit(input logic w, input logic d);
    @(negedge clk);
    sck = 1'b0; ws = w; sd = d;
    repeat (4) @(negedge clk);
    sck = 1'b1;
    repeat (4) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic send_word(input logic mode, input logic ch, input int slot,
                           input int wl, input logic [31:0] v);
    for (int j = 0; j < slot; j++) begin
      logic d, w;
      d = (j < wl) ? v[wl-1-j] : 1'b0;
      w = (mode == 1'b0 && j == slot - 1) ? ~ch : ch;
      send_bit(w, d);
    end
  endtask

  task automatic preroll(input logic mode, input logic ch);
    for (int j = 0; j < 4; j++) send_bit(~ch, 1'b1);
    send_bit(mode ? ~ch : ch, 1'b1);
  endtask

  task automatic do_reset(input logic mode);
    rst_n = 1'b0; fmt_sel = mode; sck = 1'b0; ws = 1'b0; sd = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 reset valid", valid_o, 0);
    check("R10 reset data", {left_o, right_o}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic frames(input logic mode, input int n, input int sl, input int sr,
                        input int wl, input int seed, input string tag);
    for (int k = 0; k < n; k++) begin
      logic [31:0] lv, rv;
      lv = 32'h9E3779B9 * (k + seed) ^ 32'h5A5A1234;
      rv = 32'h7F4A7C15 * (k + seed + 3) ^ 32'h0F0F8001;
      exp_q.push_back({expw(lv, wl), expw(rv, wl)});
      tag_q.push_back(tag);
      send_word(mode, 1'b0, sl, wl, lv);
      send_word(mode, 1'b1, sr, wl, rv);
    end
  endtask

  task automatic finish_seg(input string tag);
    for (int j = 0; j < 3; j++) send_bit(1'b0, 1'b0);
    repeat (20) @(negedge clk);
    check({tag, " all pairs seen"}, exp_q.size(), 0);
    exp_q.delete(); tag_q.delete();
    check("R8 pair held", {left_o, right_o}, last_pair);
  endtask

  initial begin
    do_reset(1'b0);
    preroll(1'b0, 1'b0);
    frames(1'b0, 3, 32, 32, 16, 1, "R3 standard");
    finish_seg("R3");

    do_reset(1'b1);
    preroll(1'b1, 1'b0);
    frames(1'b1, 3, 32, 32, 16, 7, "R4 left-justified");
    finish_seg("R4");

    do_reset(1'b0);
    preroll(1'b0, 1'b0);
    frames(1'b0, 2, 32, 32, 24, 11, "R5 truncate");
    finish_seg("R5");

    do_reset(1'b1);
    preroll(1'b1, 1'b0);
    frames(1'b1, 2, 32, 32, 8, 19, "R6 zero fill");
    finish_seg("R6");

    do_reset(1'b0);
    preroll(1'b0, 1'b0);
    frames(1'b0, 2, 16, 40, 16, 23, "R7 uneven slots");
    finish_seg("R7");

    do_reset(1'b1);
    preroll(1'b1, 1'b0);
    frames(1'b1, 2, 20, 33, 16, 29, "R7 uneven slots lj");
    finish_seg("R7b");

    last_pair = '0;
    do_reset(1'b0);
    preroll(1'b0, 1'b1);
    send_word(1'b0, 1'b1, 32, 16, 32'h0000BEEF);
    check("R9 no pair from lone right", {left_o, right_o}, 0);
    frames(1'b0, 2, 32, 32, 16, 31, "R9 after partial");
    finish_seg("R9");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1 actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule